// File: doc/BRIEF.md
# Asynchronous bus cycle sequencer

This block sits between a processor that runs on a fast clock and a slower motherboard bus whose timing is set by a 7 MHz reference clock. It watches the processor's address strobe, upper and lower data strobes and read/write line. It replays each bus cycle toward the motherboard with a delayed address strobe and gated data strobes. It returns a data acknowledge to the processor once the motherboard cycle has been closed cleanly. All sequencing follows edges of the reference clock. The reference clock is brought into the fast clock domain through a synchronizer chain, and its rising and falling edges become one-cycle pulses. The processor-side signals are synchronous to the fast clock.

Each motherboard cycle has a fixed shape. The processor strobe is captured on a reference falling edge, and the motherboard strobe goes out on the next rising edge. One full reference period of wait state follows. The motherboard acknowledge is looked at no earlier than the third rising edge of the cycle, so an expansion card that acknowledges too early cannot shorten the cycle. The cycle then ends on the next reference falling edge. A simple arbiter lets an external master take the bus on a reference rising edge. While the bus is granted, the motherboard strobe drivers are switched off.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is held and after it is released, with no stimulus: mb_as_n, mb_uds_n, mb_lds_n, mb_rw, cpu_dtack_n and ext_bg_n are 1 and strobe_oe is 1.
- R2: A change of ref_clk takes effect on the third rising fast clock edge after it, through SYNC_STAGES (default 2) synchronizer flops and one edge-detect flop. All sequencing and arbitration happen only on these recognized reference edges.
- R3: A low cpu_as_n is captured on a recognized reference falling edge. mb_as_n is asserted (0) on the following recognized rising edge, which is the first edge of the cycle.
- R4: The edge after the first edge is a wait state. The motherboard acknowledge is first acted on at the third rising edge of the cycle, using the mb_dtack_n level captured on the falling edge just before it. A mb_dtack_n that goes low earlier does not shorten the cycle.
- R5: If mb_dtack_n was high at that capture, each later rising edge checks the level captured on the falling edge before it, until it is seen low.
- R6: The cycle ends on the recognized falling edge after the deciding rising edge. In that same fast cycle, mb_as_n and the data strobes return to 1 and cpu_dtack_n goes to 0.
- R7: mb_uds_n and mb_lds_n are 0 only while the cycle is active and the matching cpu strobe is 0. On reads (cpu_rw=1) they follow mb_as_n. On writes with WR_DS_DELAY=1 they start one recognized falling edge after mb_as_n.
- R8: mb_rw equals cpu_rw while the cycle is active and is 1 otherwise.
- R9: cpu_dtack_n returns to 1 on the first fast clock edge at which cpu_as_n is 1. The sequencer then goes idle, and it starts a new cycle only after a fresh capture of a low cpu_as_n.
- R10: ext_br_n is captured on reference falling edges. The grant (ext_bg_n=0) is issued on a rising edge only when the sequencer is idle with no captured processor strobe. When both arrive at the same edge, the processor cycle wins and the grant follows it.
- R11: While the bus is granted, strobe_oe is 0, all motherboard strobes stay 1, and processor strobes start no cycle. The grant is released on the rising edge after a falling edge that sees both ext_br_n and ext_bgack_n at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | 7 MHz reference clock, asynchronous |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| cpu_uds_n | input | 1 | Processor upper data strobe, active low |
| cpu_lds_n | input | 1 | Processor lower data strobe, active low |
| cpu_rw | input | 1 | Processor read (1) / write (0) |
| cpu_dtack_n | output | 1 | Acknowledge to processor, active low |
| mb_as_n | output | 1 | Address strobe toward motherboard |
| mb_uds_n | output | 1 | Upper data strobe toward motherboard |
| mb_lds_n | output | 1 | Lower data strobe toward motherboard |
| mb_rw | output | 1 | Read/write toward motherboard |
| mb_dtack_n | input | 1 | Motherboard data acknowledge, active low |
| ext_br_n | input | 1 | External master bus request, active low |
| ext_bgack_n | input | 1 | External master grant acknowledge, active low |
| ext_bg_n | output | 1 | Bus grant to external master, active low |
| strobe_oe | output | 1 | Drive enable for the motherboard strobes |

## Verification
A processor strobe and an external bus request can be captured on the same reference falling edge, so both compete at the next rising edge. The bench provokes this by lowering cpu_as_n and ext_br_n on the same fast cycle, at several reference phases. It then expects a complete processor cycle with ext_bg_n held at 1. The grant must appear exactly on the first recognized rising edge after cpu_as_n is released, and not a reference period later. A second overlap is an early motherboard acknowledge during the wait state. This is judged by the end edge, which the bench computes from the edge arithmetic and compares against every fast cycle of mb_as_n and cpu_dtack_n.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ASSERT = 3'd1,
    ST_WAIT   = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_TERM   = 3'd4
  } seq_state_t;
endpackage

// File: rtl/seq_ref_edges.sv
module seq_ref_edges #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  output logic ref_rise,
  output logic ref_fall
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  // synchronizer stages followed by one history flop for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[CHAIN_W-2:0], ref_clk};
  end

  assign ref_rise = chain_q[CHAIN_W-2] & ~chain_q[CHAIN_W-1];
  assign ref_fall = ~chain_q[CHAIN_W-2] & chain_q[CHAIN_W-1];

  // R2: an edge pulse lasts exactly one fast cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ref_rise |=> !ref_rise);
endmodule

// File: rtl/seq_arbiter.sv
module seq_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic ref_fall,
  input  logic ext_br_n,
  input  logic ext_bgack_n,
  input  logic bus_free,
  output logic gnt
);
  logic br_s_q, bgack_s_q, gnt_q;
  logic br_s_d, bgack_s_d, gnt_d;

  always_comb begin
    br_s_d    = br_s_q;
    bgack_s_d = bgack_s_q;
    if (ref_fall) begin
      br_s_d    = ~ext_br_n;
      bgack_s_d = ~ext_bgack_n;
    end
  end

  always_comb begin
    gnt_d = gnt_q;
    if (ref_rise) begin
      if (!gnt_q && br_s_q && bus_free)   gnt_d = 1'b1;
      else if (gnt_q && !br_s_q && !bgack_s_q) gnt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      br_s_q    <= 1'b0;
      bgack_s_q <= 1'b0;
      gnt_q     <= 1'b0;
    end else begin
      br_s_q    <= br_s_d;
      bgack_s_q <= bgack_s_d;
      gnt_q     <= gnt_d;
    end
  end

  assign gnt = gnt_q;

  // R10: a grant only appears on a recognized rising edge
  a_r10_grant_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_q) |-> $past(ref_rise));
  // R11: the grant holds while the external master acknowledges it
  a_r11_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_q && bgack_s_q) |=> gnt_q);
endmodule

// File: rtl/seq_cycle_fsm.sv
module seq_cycle_fsm
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_rise,
  input  logic ref_fall,
  input  logic cpu_as_n,
  input  logic mb_dtack_n,
  input  logic gnt,
  output logic bus_free,
  output logic active,
  output logic ds_late_ok,
  output logic ack
);
  seq_state_t st_q, st_d;
  logic as_s_q, as_s_d;
  logic dtk_s_q, dtk_s_d;
  logic ds_on_q, ds_on_d;
  logic done_q, done_d;
  logic ack_q, ack_d;

  // capture on reference falling edges; a released strobe clears at once
  always_comb begin
    as_s_d  = as_s_q;
    dtk_s_d = dtk_s_q;
    if (cpu_as_n)      as_s_d = 1'b0;
    else if (ref_fall) as_s_d = 1'b1;
    if (ref_fall)      dtk_s_d = ~mb_dtack_n;
  end

  always_comb begin
    st_d    = st_q;
    ds_on_d = ds_on_q;
    done_d  = done_q;
    unique case (st_q)
      ST_IDLE:   if (ref_rise && as_s_q && !gnt) st_d = ST_ASSERT;
      ST_ASSERT: begin
        if (ref_rise) st_d = ST_WAIT;
        if (ref_fall) ds_on_d = 1'b1;
      end
      ST_WAIT:   if (ref_rise) st_d = dtk_s_q ? ST_TERM : ST_SAMPLE;
      ST_SAMPLE: if (ref_rise && dtk_s_q) st_d = ST_TERM;
      ST_TERM: begin
        if (ref_fall) done_d = 1'b1;
        if (done_q && cpu_as_n) st_d = ST_IDLE;
      end
      default:   st_d = ST_IDLE;
    endcase
    if (st_d == ST_IDLE) begin
      ds_on_d = 1'b0;
      done_d  = 1'b0;
    end
  end

  always_comb ack_d = ~cpu_as_n & (done_q | (st_q == ST_TERM && ref_fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      as_s_q  <= 1'b0;
      dtk_s_q <= 1'b0;
      ds_on_q <= 1'b0;
      done_q  <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      as_s_q  <= as_s_d;
      dtk_s_q <= dtk_s_d;
      ds_on_q <= ds_on_d;
      done_q  <= done_d;
      ack_q   <= ack_d;
    end
  end

  assign bus_free   = (st_q == ST_IDLE) && !as_s_q;
  assign active     = (st_q != ST_IDLE) && !done_q;
  assign ds_late_ok = ds_on_q;
  assign ack        = ack_q;

  // R3: leaving idle needs a recognized rising edge
  a_r3_start_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && !ref_rise) |=> st_q == ST_IDLE);
  // R4: the first edge is always followed by the wait state
  a_r4_wait_state: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ASSERT) |=> (st_q == ST_ASSERT || st_q == ST_WAIT));
  // R6: the processor acknowledge starts on a falling reference edge
  a_r6_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_q) |-> $past(ref_fall));
  // R9: a released processor strobe drops the acknowledge next cycle
  a_r9_ack_release: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_as_n |=> !ack_q);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq #(
  parameter int SYNC_STAGES = 2,
  parameter bit WR_DS_DELAY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_clk,
  input  logic cpu_as_n,
  input  logic cpu_uds_n,
  input  logic cpu_lds_n,
  input  logic cpu_rw,
  output logic cpu_dtack_n,
  output logic mb_as_n,
  output logic mb_uds_n,
  output logic mb_lds_n,
  output logic mb_rw,
  input  logic mb_dtack_n,
  input  logic ext_br_n,
  input  logic ext_bgack_n,
  output logic ext_bg_n,
  output logic strobe_oe
);
  logic [1:0] rst_q;
  logic rst_i_n;
  logic ref_rise, ref_fall;
  logic bus_free, active, ds_late_ok, ack, gnt, ds_gate;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  seq_ref_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
    .clk(clk), .rst_n(rst_i_n), .ref_clk(ref_clk),
    .ref_rise(ref_rise), .ref_fall(ref_fall)
  );

  seq_cycle_fsm u_fsm (
    .clk(clk), .rst_n(rst_i_n), .ref_rise(ref_rise), .ref_fall(ref_fall),
    .cpu_as_n(cpu_as_n), .mb_dtack_n(mb_dtack_n), .gnt(gnt),
    .bus_free(bus_free), .active(active), .ds_late_ok(ds_late_ok), .ack(ack)
  );

  seq_arbiter u_arb (
    .clk(clk), .rst_n(rst_i_n), .ref_rise(ref_rise), .ref_fall(ref_fall),
    .ext_br_n(ext_br_n), .ext_bgack_n(ext_bgack_n), .bus_free(bus_free),
    .gnt(gnt)
  );

  generate
    if (WR_DS_DELAY) begin : g_wr_late
      assign ds_gate = cpu_rw | ds_late_ok;
    end else begin : g_wr_early
      assign ds_gate = 1'b1;
    end
  endgenerate

  assign mb_as_n     = ~active;
  assign mb_uds_n    = ~(active & ds_gate & ~cpu_uds_n);
  assign mb_lds_n    = ~(active & ds_gate & ~cpu_lds_n);
  assign mb_rw       = active ? cpu_rw : 1'b1;
  assign cpu_dtack_n = ~ack;
  assign ext_bg_n    = ~gnt;
  assign strobe_oe   = ~gnt;

  // R11: with drivers released no motherboard strobe is asserted
  a_r11_quiet_when_granted: assert property (@(posedge clk) disable iff (!rst_i_n)
    !strobe_oe |-> (mb_as_n && mb_uds_n && mb_lds_n));
endmodule

// File: tb/sim_bus_cycle_seq.sv
module sim_bus_cycle_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic cpu_as_n = 1'b1, cpu_uds_n = 1'b1, cpu_lds_n = 1'b1, cpu_rw = 1'b1;
  logic mb_dtack_n = 1'b1, ext_br_n = 1'b1, ext_bgack_n = 1'b1;
  logic cpu_dtack_n, mb_as_n, mb_uds_n, mb_lds_n, mb_rw, ext_bg_n, strobe_oe;
  int cyc = 0;
  int n_cmp = 0;
  int n_bad = 0;

  bus_cycle_seq u0 (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk),
    .cpu_as_n(cpu_as_n), .cpu_uds_n(cpu_uds_n), .cpu_lds_n(cpu_lds_n),
    .cpu_rw(cpu_rw), .cpu_dtack_n(cpu_dtack_n), .mb_as_n(mb_as_n),
    .mb_uds_n(mb_uds_n), .mb_lds_n(mb_lds_n), .mb_rw(mb_rw),
    .mb_dtack_n(mb_dtack_n), .ext_br_n(ext_br_n), .ext_bgack_n(ext_bgack_n),
    .ext_bg_n(ext_bg_n), .strobe_oe(strobe_oe)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  // reference clock: rises at negedges where cyc%8==0, falls where cyc%8==4;
  // per R2 the design acts on posedges with cyc%8==3 (rise) and cyc%8==7 (fall)
  always @(negedge clk) ref_clk <= ((cyc % 8) < 4);

  task automatic chk(input string tag, input logic act, input logic exp, input int c);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", tag, c, act, exp);
    end
  endtask

  function automatic int next_fall(input int from);
    int v = from;
    while (v % 8 != 7) v++;
    return v;
  endfunction

  task automatic run_cycle(input int ph, input int dly, input bit rw,
                           input bit su, input bit sl, input bit with_br);
    int a, r1, dd, fd, e_end, dsr, c;
    bit act;
    @(negedge clk);
    while (cyc % 8 != ph) @(negedge clk);
    a = cyc;
    cpu_rw = rw; cpu_uds_n = !su; cpu_lds_n = !sl; cpu_as_n = 1'b0;
    if (with_br) ext_br_n = 1'b0;
    if (dly == 0) mb_dtack_n = 1'b0;
    r1 = next_fall(a + 1) + 4;            // R3
    dd = a + dly;
    fd = next_fall(dd + 1);
    if (fd < r1 + 12) fd = r1 + 12;       // R4 earliest capture, R5 later
    e_end = fd + 8;                       // R6
    dsr = rw ? r1 : r1 + 4;               // R7
    do begin
      @(negedge clk);
      c = cyc;
      act = (c >= r1) && (c < e_end);
      chk("R3 R4 R5 mb_as_n", mb_as_n, !act, c);
      chk("R7 mb_uds_n", mb_uds_n, !(act && su && c >= dsr), c);
      chk("R7 mb_lds_n", mb_lds_n, !(act && sl && c >= dsr), c);
      chk("R8 mb_rw", mb_rw, act ? rw : 1'b1, c);
      chk("R6 R9 cpu_dtack_n", cpu_dtack_n, !(c >= e_end && c <= e_end + 2), c);
      chk("R10 ext_bg_n", ext_bg_n, !(with_br && c >= e_end + 4), c);
      chk("R10 strobe_oe", strobe_oe, !(with_br && c >= e_end + 4), c);
      if (c == dd) mb_dtack_n = 1'b0;
      if (c == e_end + 2) begin
        cpu_as_n = 1'b1; cpu_uds_n = 1'b1; cpu_lds_n = 1'b1;
        cpu_rw = 1'b1; mb_dtack_n = 1'b1;
      end
    end while (c < e_end + 6);
  endtask

  task automatic release_bus();
    int x, rel, c;
    @(negedge clk);
    x = cyc;
    ext_br_n = 1'b1; ext_bgack_n = 1'b1;
    rel = next_fall(x + 1) + 4;
    do begin
      @(negedge clk);
      c = cyc;
      chk("R11 ext_bg_n release", ext_bg_n, c >= rel, c);
      chk("R11 strobe_oe release", strobe_oe, c >= rel, c);
    end while (c < rel + 2);
  endtask

  task automatic grant_with_cpu(input int ph);
    int b, g, c;
    @(negedge clk);
    while (cyc % 8 != ph) @(negedge clk);
    b = cyc;
    ext_br_n = 1'b0;
    g = next_fall(b + 1) + 4;
    do begin
      @(negedge clk);
      c = cyc;
      chk("R10 ext_bg_n grant", ext_bg_n, !(c >= g), c);
      chk("R10 strobe_oe grant", strobe_oe, !(c >= g), c);
      chk("R10 mb_as_n idle", mb_as_n, 1'b1, c);
    end while (c < g + 2);
    ext_bgack_n = 1'b0; ext_br_n = 1'b1;
    cpu_as_n = 1'b0; cpu_uds_n = 1'b0; cpu_lds_n = 1'b0; cpu_rw = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      chk("R11 mb_as_n granted", mb_as_n, 1'b1, cyc);
      chk("R11 mb_uds_n granted", mb_uds_n, 1'b1, cyc);
      chk("R11 mb_lds_n granted", mb_lds_n, 1'b1, cyc);
      chk("R11 cpu_dtack_n granted", cpu_dtack_n, 1'b1, cyc);
      chk("R11 ext_bg_n held", ext_bg_n, 1'b0, cyc);
      chk("R11 strobe_oe off", strobe_oe, 1'b0, cyc);
    end
    cpu_as_n = 1'b1; cpu_uds_n = 1'b1; cpu_lds_n = 1'b1; cpu_rw = 1'b1;
    repeat (2) @(negedge clk);
    release_bus();
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R9 no stale cycle", mb_as_n, 1'b1, cyc);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R1 mb_as_n", mb_as_n, 1'b1, cyc);
    chk("R1 mb_uds_n", mb_uds_n, 1'b1, cyc);
    chk("R1 mb_lds_n", mb_lds_n, 1'b1, cyc);
    chk("R1 mb_rw", mb_rw, 1'b1, cyc);
    chk("R1 cpu_dtack_n", cpu_dtack_n, 1'b1, cyc);
    chk("R1 ext_bg_n", ext_bg_n, 1'b1, cyc);
    chk("R1 strobe_oe", strobe_oe, 1'b1, cyc);
    rst_n = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk("R1 mb_as_n after release", mb_as_n, 1'b1, cyc);
      chk("R1 cpu_dtack_n after release", cpu_dtack_n, 1'b1, cyc);
    end
    // R2 R3 R4 R5 R6 R7 R8 R9: sweep phases, acknowledge delays, direction, lanes
    for (int ph = 0; ph < 8; ph++)
      for (int k = 0; k < 6; k++)
        for (int rw = 0; rw < 2; rw++)
          for (int ln = 0; ln < 3; ln++) begin
            int dl;
            case (k)
              0: dl = 0;  1: dl = 9;  2: dl = 18;
              3: dl = 26; 4: dl = 33; default: dl = 47;
            endcase
            run_cycle(ph, dl, rw[0], ln != 2, ln != 1, 1'b0);
            repeat (3) @(negedge clk);
          end
    // R11 grant with processor strobes blocked
    grant_with_cpu(2);
    grant_with_cpu(5);
    // R10 processor strobe and bus request captured together
    for (int ph = 0; ph < 8; ph += 3) begin
      run_cycle(ph, 0, 1'b1, 1'b1, 1'b1, 1'b1);
      release_bus();
      repeat (3) @(negedge clk);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog: actual still running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule